// File: doc/BRIEF.md
# Three-Stage Accumulator Processor with Jump Flush

This block is an 8-bit accumulator machine cut into three overlapping stages: instruction fetch, decode with operand read, and execute. While one instruction executes, the next is being decoded and the one after that is being fetched, so in straight-line code one instruction completes every cycle. Program and data share one address space that the block sees through two read ports and one write port, so a fetch and an operand read can happen in the same cycle.

Each instruction is one byte. The top three bits select the operation and the low five bits give a memory address (or the jump target). When a jump reaches execute, the two younger instructions already in decode and fetch are no longer the ones that should run next. They are discarded, and fetching restarts at the target. There is no prediction and no delay slot. An input instruction that finds no valid input data freezes all three stages until data arrives. A store that is followed directly by a read of the same address gets the accumulator value through a bypass around memory.

Top module: `acc_pipe3`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears the accumulator to 0, sets the fetch address to 0 and marks decode and execute empty. While the block is in reset, `out_valid`, `dmem_we` and `in_take` are 0.
- R2: Bits [7:5] of an instruction hold the operation and bits [4:0] hold the address. The codes are: 000 no operation, 001 add memory to accumulator, 010 subtract memory from accumulator, 011 read input into accumulator, 100 output accumulator, 101 store accumulator to memory, 110 load memory into accumulator, 111 jump to address.
- R3: Add and subtract wrap modulo 256, and load replaces the accumulator with the memory byte.
- R4: In straight-line code the block completes one instruction per cycle, so adjacent output instructions produce `out_valid` in adjacent cycles.
- R5: A jump in execute discards the two younger instructions. A discarded instruction never stores, outputs or changes the accumulator, and the next instruction to execute is the one at the target address.
- R6: Exactly two empty execute cycles separate a jump from its target instruction, so an output just before a jump and an output at the target are four cycles apart.
- R7: A load, add or subtract that directly follows a store to the same address uses the stored accumulator value, not the old memory contents.
- R8: An input instruction in execute with `in_valid` low holds all three stages. `in_take` is high in exactly the cycle the data is consumed, and no instruction is lost or repeated across the stall.
- R9: For any program, the output sequence, the final accumulator and the final data memory match a plain one-instruction-at-a-time interpretation of the same program with the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 5 | Instruction fetch address |
| imem_rdata | input | 8 | Instruction byte at `imem_addr`, combinational |
| dmem_raddr | output | 5 | Operand read address |
| dmem_rdata | input | 8 | Data byte at `dmem_raddr`, combinational |
| dmem_we | output | 1 | Write strobe, taken at the rising edge |
| dmem_waddr | output | 5 | Write address |
| dmem_wdata | output | 8 | Write data |
| in_valid | input | 1 | Input data is offered |
| in_data | input | 8 | Input byte |
| in_take | output | 1 | Input byte is consumed at this edge |
| out_valid | output | 1 | Output byte is valid this cycle |
| out_data | output | 8 | Output byte |
| acc | output | 8 | Current accumulator |

## Verification
The hardest situation to reach from the ports is a jump whose discarded younger instructions would each cause a visible effect if they leaked through: a store into a marked location and an output. The jump test places exactly such instructions in the two slots behind the jump. It then checks that memory kept its marker, that only the intended outputs appear, and that the spacing around the jump is four cycles. The input stall is reached by a memory model in the bench that holds `in_valid` low for several cycles while an input instruction sits in execute. The store-then-read bypass is reached by placing the dependent load or add right after the store, with a different value left in memory beforehand.

// File: rtl/acc_pipe3_pkg.sv
// Shared operation codes for the three-stage accumulator processor.
// Assumes the operation field is the top three bits of each instruction.
package acc_pipe3_pkg;
    localparam int unsigned OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_NOP = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_IN  = 3'd3,
        OP_OUT = 3'd4,
        OP_STO = 3'd5,
        OP_LDA = 3'd6,
        OP_JMP = 3'd7
    } op_e;
endpackage

// File: rtl/acc_pipe3_fetch.sv
// Fetch stage: owns the program counter. It steps by one each cycle,
// holds during a stall, and loads the jump target on a flush.
// Assumes that stall and redirect are never high together.
module acc_pipe3_fetch #(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] fetch_addr
);
    logic [AW-1:0] pc_q;

    // Program counter: reset to 0, redirect on jump, otherwise step.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= '0;
        else if (redirect) pc_q <= target;
        else if (!stall)   pc_q <= pc_q + 1'b1;
    end

    assign fetch_addr = pc_q;

    a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> fetch_addr == $past(fetch_addr));
endmodule

// File: rtl/acc_pipe3_decode.sv
// Decode stage: holds the fetched instruction with its valid bit and
// reads its operand. It also holds the register that feeds execute.
// A store in execute to the operand address is bypassed from the
// accumulator, because that memory write only lands at the next edge.
module acc_pipe3_decode #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          flush,
    input  logic [DW-1:0] f_instr,
    output logic [AW-1:0] opnd_addr,
    input  logic [DW-1:0] opnd_rdata,
    input  logic          fwd_we,
    input  logic [AW-1:0] fwd_addr,
    input  logic [DW-1:0] fwd_data,
    output logic          e_valid,
    output logic [DW-1:0] e_instr,
    output logic [DW-1:0] e_operand
);
    logic          d_valid;
    logic [DW-1:0] d_instr;
    logic [DW-1:0] opnd_sel;

    assign opnd_addr = d_instr[AW-1:0];

    // Operand choice: a same-address store in execute wins over memory.
    always_comb begin
        if (fwd_we && fwd_addr == opnd_addr) opnd_sel = fwd_data;
        else                                 opnd_sel = opnd_rdata;
    end

    // Stage registers: cleared on flush, frozen on stall, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_valid   <= 1'b0;
            e_valid   <= 1'b0;
            d_instr   <= '0;
            e_instr   <= '0;
            e_operand <= '0;
        end else if (flush) begin
            d_valid <= 1'b0;
            e_valid <= 1'b0;
        end else if (!stall) begin
            d_valid   <= 1'b1;
            d_instr   <= f_instr;
            e_valid   <= d_valid;
            e_instr   <= d_instr;
            e_operand <= opnd_sel;
        end
    end

    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && fwd_we && fwd_addr == opnd_addr && !stall && !flush)
        |=> e_operand == $past(fwd_data));

    a_r8_exec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> e_valid && $stable(e_instr));
endmodule

// File: rtl/acc_pipe3_exec.sv
// Execute stage: owns the accumulator and drives every side effect
// (store, output, input take). It raises a flush on a jump and a stall
// while an input instruction waits. Assumes e_valid is low for empty slots.
module acc_pipe3_exec
    import acc_pipe3_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          e_valid,
    input  logic [DW-1:0] e_instr,
    input  logic [DW-1:0] e_operand,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] acc,
    output logic          stall,
    output logic          flush,
    output logic [AW-1:0] target,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          in_take
);
    op_e           op;
    logic [DW-1:0] acc_q;

    assign op = op_e'(e_instr[DW-1 -: OPW]);

    // Side-effect strobes, each gated by the execute valid bit.
    always_comb begin
        stall     = e_valid && op == OP_IN && !in_valid;
        in_take   = e_valid && op == OP_IN && in_valid;
        flush     = e_valid && op == OP_JMP;
        mem_we    = e_valid && op == OP_STO;
        out_valid = e_valid && op == OP_OUT;
    end

    assign target    = e_instr[AW-1:0];
    assign mem_waddr = e_instr[AW-1:0];
    assign mem_wdata = acc_q;
    assign out_data  = acc_q;
    assign acc       = acc_q;

    // Accumulator update for arithmetic, load and consumed input.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (e_valid) begin
            case (op)
                OP_ADD:  acc_q <= acc_q + e_operand;
                OP_SUB:  acc_q <= acc_q - e_operand;
                OP_LDA:  acc_q <= e_operand;
                OP_IN:   if (in_valid) acc_q <= in_data;
                default: acc_q <= acc_q;
            endcase
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (acc == '0 && !e_valid));

    a_r6_two_bubbles: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !e_valid ##1 !e_valid);

    a_r5_one_effect: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, out_valid, in_take, flush}));

    a_r8_take_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        in_take |=> !$past(stall));
endmodule

// File: rtl/acc_pipe3.sv
// Top of the three-stage accumulator processor. It wires fetch, decode
// and execute together. Memory lives outside the block and is read
// combinationally through two ports and written at the clock edge.
module acc_pipe3 #(
    parameter int unsigned DW = 8,
    localparam int unsigned AW = DW - acc_pipe3_pkg::OPW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] imem_addr,
    input  logic [DW-1:0] imem_rdata,
    output logic [AW-1:0] dmem_raddr,
    input  logic [DW-1:0] dmem_rdata,
    output logic          dmem_we,
    output logic [AW-1:0] dmem_waddr,
    output logic [DW-1:0] dmem_wdata,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_take,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [DW-1:0] acc
);
    logic          stall;
    logic          flush;
    logic [AW-1:0] target;
    logic          e_valid;
    logic [DW-1:0] e_instr;
    logic [DW-1:0] e_operand;

    acc_pipe3_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .stall(stall), .redirect(flush),
        .target(target), .fetch_addr(imem_addr)
    );

    acc_pipe3_decode #(.DW(DW), .AW(AW)) u_decode (
        .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
        .f_instr(imem_rdata), .opnd_addr(dmem_raddr), .opnd_rdata(dmem_rdata),
        .fwd_we(dmem_we), .fwd_addr(dmem_waddr), .fwd_data(dmem_wdata),
        .e_valid(e_valid), .e_instr(e_instr), .e_operand(e_operand)
    );

    acc_pipe3_exec #(.DW(DW), .AW(AW)) u_exec (
        .clk(clk), .rst_n(rst_n), .e_valid(e_valid), .e_instr(e_instr),
        .e_operand(e_operand), .in_valid(in_valid), .in_data(in_data),
        .acc(acc), .stall(stall), .flush(flush), .target(target),
        .mem_we(dmem_we), .mem_waddr(dmem_waddr), .mem_wdata(dmem_wdata),
        .out_valid(out_valid), .out_data(out_data), .in_take(in_take)
    );
endmodule

// File: tb/acc_pipe3_bench.sv
// Bench for acc_pipe3: a memory model, an input feeder, an output
// monitor, a table-driven arithmetic walk, directed tests and a
// comparison against a one-instruction-at-a-time reference model.
module acc_pipe3_bench;
    localparam logic [2:0] NOP = 3'd0, ADD = 3'd1, SUB = 3'd2, INP = 3'd3,
                           OUTP = 3'd4, STO = 3'd5, LDA = 3'd6, JMP = 3'd7;

    // sel (1 = subtract), a, b
    localparam logic [16:0] VEC [0:5] = '{
        {1'b0, 8'd5,   8'd3},
        {1'b0, 8'd200, 8'd100},
        {1'b0, 8'd255, 8'd1},
        {1'b1, 8'd3,   8'd5},
        {1'b1, 8'd128, 8'd1},
        {1'b1, 8'd0,   8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] imem_addr, dmem_raddr, dmem_waddr;
    logic [7:0] imem_rdata, dmem_rdata, dmem_wdata, in_data, out_data, acc;
    logic       dmem_we, in_valid, in_take, out_valid;

    logic [7:0] mem [32];
    logic [7:0] ref_mem [32];
    logic [7:0] in_vals [8];
    int         in_n = 0, in_idx = 0, in_gap = 0, gap_cnt = 0;
    logic [7:0] tr_val [16];
    int         tr_cyc [16];
    int         n_tr = 0;
    logic [7:0] ref_out [16];
    int         ref_n;
    logic [7:0] ref_acc;
    int         cyc = 0, total = 0, bad = 0;

    always #4 clk = ~clk;

    acc_pipe3 u_acc_pipe3 (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
        .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata), .in_valid(in_valid),
        .in_data(in_data), .in_take(in_take), .out_valid(out_valid),
        .out_data(out_data), .acc(acc)
    );

    assign imem_rdata = mem[imem_addr];
    assign dmem_rdata = mem[dmem_raddr];

    always @(posedge clk) begin
        if (dmem_we === 1'b1) mem[dmem_waddr] <= dmem_wdata;
    end

    // Watchdog and cycle count.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && out_valid === 1'b1 && n_tr < 16) begin
            tr_val[n_tr] = out_data;
            tr_cyc[n_tr] = cyc;
            n_tr = n_tr + 1;
        end
    end

    // Input feeder: drive at the falling edge, note consumption just before the rising edge.
    initial begin
        in_valid = 1'b0;
        in_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (gap_cnt > 0) begin
                in_valid = 1'b0;
                gap_cnt = gap_cnt - 1;
            end else if (in_idx < in_n) begin
                in_valid = 1'b1;
                in_data  = in_vals[in_idx];
            end else in_valid = 1'b0;
            #3;
            if (rst_n && in_valid && in_take === 1'b1) begin
                in_idx = in_idx + 1;
                gap_cnt = in_gap;
            end
        end
    end

    function automatic logic [7:0] ins(input logic [2:0] op, input int a);
        return {op, 5'(a)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic start_prog(input int gap);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 32; i++) mem[i] = ins(JMP, i);
        n_tr = 0; in_n = 0; in_idx = 0; in_gap = gap; gap_cnt = gap;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Reference interpreter: one instruction at a time, stops at a self-jump.
    task automatic ref_run();
        int pc = 0, k = 0;
        logic [7:0] ir, a;
        for (int i = 0; i < 32; i++) ref_mem[i] = mem[i];
        ref_n = 0; ref_acc = 8'h00;
        for (int step = 0; step < 200; step++) begin
            ir = ref_mem[pc];
            a  = ref_mem[ir[4:0]];
            if (ir[7:5] == JMP && int'(ir[4:0]) == pc) break;
            pc = (pc + 1) % 32;
            case (ir[7:5])
                ADD:  ref_acc = ref_acc + a;
                SUB:  ref_acc = ref_acc - a;
                LDA:  ref_acc = a;
                INP:  begin ref_acc = in_vals[k]; k++; end
                OUTP: begin ref_out[ref_n] = ref_acc; ref_n++; end
                STO:  ref_mem[ir[4:0]] = ref_acc;
                JMP:  pc = int'(ir[4:0]);
                default: ;
            endcase
        end
    endtask

    initial begin
        // R1: reset state
        start_prog(0);
        repeat (2) @(negedge clk);
        check("R1 acc", acc, 8'h00);
        check("R1 fetch addr", imem_addr, 5'd0);
        check("R1 strobes", {out_valid, dmem_we, in_take}, 3'b000);

        // R2 R3: table walk of load then add or subtract, then output
        for (int v = 0; v < 6; v++) begin
            start_prog(0);
            mem[0] = ins(LDA, 16);
            mem[1] = ins(VEC[v][16] ? SUB : ADD, 17);
            mem[2] = ins(OUTP, 0);
            mem[16] = VEC[v][15:8];
            mem[17] = VEC[v][7:0];
            run(12);
            check("R3 count", n_tr, 1);
            check("R2 R3 value", tr_val[0],
                  VEC[v][16] ? 8'(VEC[v][15:8] - VEC[v][7:0]) : 8'(VEC[v][15:8] + VEC[v][7:0]));
        end

        // R4: one instruction per cycle
        start_prog(0);
        mem[0] = ins(LDA, 16); mem[1] = ins(OUTP, 0); mem[2] = ins(ADD, 17);
        mem[3] = ins(OUTP, 0); mem[4] = ins(OUTP, 0);
        mem[16] = 8'd7; mem[17] = 8'd1;
        run(14);
        check("R4 count", n_tr, 3);
        check("R4 values", {tr_val[0], tr_val[1], tr_val[2]}, {8'd7, 8'd8, 8'd8});
        check("R4 gap add", tr_cyc[1] - tr_cyc[0], 2);
        check("R4 gap adjacent", tr_cyc[2] - tr_cyc[1], 1);

        // R5 R6: jump discards the two younger instructions
        start_prog(0);
        mem[0] = ins(LDA, 16); mem[1] = ins(OUTP, 0); mem[2] = ins(JMP, 6);
        mem[3] = ins(STO, 17); mem[4] = ins(OUTP, 0); mem[5] = ins(ADD, 16);
        mem[6] = ins(OUTP, 0);
        mem[16] = 8'd9; mem[17] = 8'h55;
        run(16);
        check("R5 count", n_tr, 2);
        check("R5 values", {tr_val[0], tr_val[1]}, {8'd9, 8'd9});
        check("R5 no store", mem[17], 8'h55);
        check("R5 acc", acc, 8'd9);
        check("R6 gap", tr_cyc[1] - tr_cyc[0], 4);

        // R7: store then read of the same address
        start_prog(0);
        mem[0] = ins(LDA, 16); mem[1] = ins(ADD, 16); mem[2] = ins(STO, 20);
        mem[3] = ins(LDA, 20); mem[4] = ins(OUTP, 0); mem[5] = ins(STO, 21);
        mem[6] = ins(ADD, 21); mem[7] = ins(OUTP, 0);
        mem[16] = 8'h21; mem[20] = 8'h99; mem[21] = 8'h13;
        run(16);
        check("R7 count", n_tr, 2);
        check("R7 load after store", tr_val[0], 8'h42);
        check("R7 add after store", tr_val[1], 8'h84);

        // R8: input stall with gaps
        start_prog(5);
        mem[0] = ins(INP, 0); mem[1] = ins(OUTP, 0); mem[2] = ins(INP, 0);
        mem[3] = ins(ADD, 16); mem[4] = ins(OUTP, 0);
        mem[16] = 8'd1;
        in_vals[0] = 8'h30; in_vals[1] = 8'h70; in_n = 2;
        run(30);
        check("R8 count", n_tr, 2);
        check("R8 values", {tr_val[0], tr_val[1]}, {8'h30, 8'h71});
        check("R8 consumed", in_idx, 2);
        check("R8 held before input", (tr_cyc[0] > 6) ? 1 : 0, 1);

        // R9: mixed program against the reference interpreter
        start_prog(2);
        mem[0] = ins(INP, 0);   mem[1] = ins(STO, 24);  mem[2] = ins(ADD, 24);
        mem[3] = ins(OUTP, 0);  mem[4] = ins(JMP, 8);   mem[5] = ins(OUTP, 0);
        mem[6] = ins(OUTP, 0);  mem[7] = ins(OUTP, 0);  mem[8] = ins(SUB, 25);
        mem[9] = ins(STO, 26);  mem[10] = ins(LDA, 26); mem[11] = ins(ADD, 24);
        mem[12] = ins(OUTP, 0); mem[13] = ins(INP, 0);  mem[14] = ins(SUB, 24);
        mem[15] = ins(OUTP, 0); mem[16] = ins(STO, 27); mem[17] = ins(NOP, 0);
        mem[18] = ins(JMP, 18);
        mem[24] = 8'h00; mem[25] = 8'd3; mem[26] = 8'h00; mem[27] = 8'h00;
        in_vals[0] = 8'h11; in_vals[1] = 8'h40; in_n = 2;
        ref_run();
        run(50);
        check("R9 count", n_tr, ref_n);
        for (int i = 0; i < ref_n; i++) check("R9 output", tr_val[i], ref_out[i]);
        check("R9 acc", acc, ref_acc);
        for (int i = 24; i < 28; i++) check("R9 memory", mem[i], ref_mem[i]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule